// File: doc/BRIEF.md
# Givens QR Triangular Update Engine

This block holds the upper-triangular factor R and its right-hand column u for a small real least-squares problem with N data inputs and one reference input. Each accepted snapshot (x1..xN, y) is folded into the stored triangle by a chain of Givens rotations. Row by row, the incoming element that sits under the diagonal is annihilated. The rotated remainder of the vector then moves on to the next row. After any number of snapshots, the weight vector w that solves R·w = u is the least-squares fit of y onto the x inputs. Back-substitution is done outside the block.

The design does not build a full systolic grid. It has one shared boundary unit and one shared rotate unit. The boundary unit contains a bit-serial square root and an iterative divider. The rotate unit applies one rotation per clock. The rows are visited in order. Inside a row, the columns to the right of the diagonal are visited left to right, and the u column comes last. Data is signed Q2.14 fixed point. A combinational read port exposes every stored entry. A synchronous clear input starts a new problem.

Top module: `qr_givens_engine`

## Requirements
- R1: After reset or clear, every stored entry reads zero. An entry below the diagonal (column < row) always reads zero.
- R2: When a snapshot is processed, the diagonal of row i becomes d = sqrt(r² + x²) (truncated, never negative). Here r is the old diagonal and x is the incoming element i.
- R3: Data is signed 16-bit Q2.14 (value = code / 16384). Snapshot element k (k = 0..N-1 for x, k = N for y) sits at in_data_i[16k +: 16]. The rotation parameters are c = r/d and s = x/d, and s carries the sign of x.
- R4: For each column j to the right of the diagonal in row i, the stored value a becomes c·a + s·b. The incoming value b becomes c·b − s·a, and that new b is fed to row i+1. Results are truncated toward minus infinity and saturated to 16 bits.
- R5: If r and x are both zero, the row uses c = 1 and s = 0. The row's stored entries and the incoming vector then pass through unchanged, and the diagonal stays zero.
- R6: in_ready_o is high only when the block is idle. A snapshot is accepted on a clock edge with in_valid_i and in_ready_o both high. in_ready_o is low from the next cycle until all N rows have been updated.
- R7: clear_i, even in the middle of an update, zeroes the whole triangle and makes the block idle in the next cycle.
- R8: rd_data_o shows entry (rd_row_i, rd_col_i) combinationally, with column N holding u of that row. An address outside N rows or N+1 columns reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of the triangle and the sequencer |
| in_valid_i | input | 1 | Snapshot valid |
| in_ready_o | output | 1 | Block idle, snapshot can be taken |
| in_data_i | input | (N+1)·16 | Packed snapshot x1..xN, y |
| rd_row_i | input | clog2(N+1) | Read row address |
| rd_col_i | input | clog2(N+1) | Read column address |
| rd_data_o | output | 16 | Stored entry at the read address |

## Verification
A wrong rotation, root or divide corrupts R or u at once. The bad value appears at the read port as soon as in_ready_o rises again after the offending snapshot. Later snapshots spread the error into every row below, so comparing against a real-valued reference update after each problem exposes it within one snapshot. Sequencing faults show up on in_ready_o within one cycle of acceptance or clear. They also show up as nonzero entries below the diagonal or as a negative diagonal.

// File: rtl/qr_pkg.sv
package qr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_SQRT,
    ST_DIVC,
    ST_DIVS,
    ST_ROT
  } qr_state_e;
endpackage

// File: rtl/qr_isqrt.sv
// Bit-serial integer square root, one result bit per cycle.
module qr_isqrt #(
  parameter int W = 16,
  localparam int RMW = W + 2,
  localparam int CNTW = $clog2(W + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [2*W-1:0] rad_i,
  output logic           done_o,
  output logic [W-1:0]   root_o
);
  logic [2*W-1:0] rad_q;
  logic [RMW-1:0] rem_q;
  logic [W-1:0]   root_q;
  logic [CNTW-1:0] cnt_q;
  logic           busy_q, done_q;
  logic [RMW+1:0] rem_sh, trial;
  logic           ge;

  assign rem_sh = {rem_q, rad_q[2*W-1:2*W-2]};
  assign trial  = {2'b00, root_q, 2'b01};
  assign ge     = rem_sh >= trial;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rad_q  <= '0;
      rem_q  <= '0;
      root_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rad_q  <= rad_i;
        rem_q  <= '0;
        root_q <= '0;
        cnt_q  <= CNTW'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q  <= ge ? RMW'(rem_sh - trial) : RMW'(rem_sh);
        root_q <= {root_q[W-2:0], ge};
        rad_q  <= {rad_q[2*W-3:0], 2'b00};
        cnt_q  <= cnt_q - CNTW'(1);
        if (cnt_q == CNTW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign root_o = root_q;
endmodule

// File: rtl/qr_divider.sv
// Restoring divider, one quotient bit per cycle.
module qr_divider #(
  parameter int NW = 30,
  parameter int DW = 16,
  localparam int CNTW = $clog2(NW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [NW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic          done_o,
  output logic [NW-1:0] quo_o
);
  logic [NW-1:0]   num_q, quo_q;
  logic [DW-1:0]   den_q, rem_q;
  logic [CNTW-1:0] cnt_q;
  logic            busy_q, done_q;
  logic [DW:0]     rem_sh;
  logic            ge;

  assign rem_sh = {rem_q, num_q[NW-1]};
  assign ge     = rem_sh >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        num_q  <= num_i;
        den_q  <= den_i;
        rem_q  <= '0;
        quo_q  <= '0;
        cnt_q  <= CNTW'(NW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q  <= ge ? DW'(rem_sh - {1'b0, den_q}) : DW'(rem_sh);
        quo_q  <= {quo_q[NW-2:0], ge};
        num_q  <= {num_q[NW-2:0], 1'b0};
        cnt_q  <= cnt_q - CNTW'(1);
        if (cnt_q == CNTW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
endmodule

// File: rtl/qr_rotate.sv
// Shared rotate unit: a' = c*a + s*b, b' = c*b - s*a, saturated.
module qr_rotate #(
  parameter int W = 16,
  parameter int FRAC = 14
) (
  input  logic signed [W-1:0] c_i,
  input  logic signed [W-1:0] s_i,
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic signed [W-1:0] a_o,
  output logic signed [W-1:0] b_o
);
  localparam logic signed [2*W:0] MAXV = (2*W+1)'((1 << (W - 1)) - 1);
  localparam logic signed [2*W:0] MINV = -(2*W+1)'(1 << (W - 1));

  logic signed [2*W-1:0] ca, sb, cb, sa;
  logic signed [2*W:0]   sum_a, sum_b, sh_a, sh_b;

  assign ca = c_i * a_i;
  assign sb = s_i * b_i;
  assign cb = c_i * b_i;
  assign sa = s_i * a_i;
  assign sum_a = (2*W+1)'(ca) + (2*W+1)'(sb);
  assign sum_b = (2*W+1)'(cb) - (2*W+1)'(sa);
  assign sh_a  = sum_a >>> FRAC;
  assign sh_b  = sum_b >>> FRAC;

  always_comb begin
    if (sh_a > MAXV)      a_o = W'(MAXV);
    else if (sh_a < MINV) a_o = W'(MINV);
    else                  a_o = W'(sh_a);
    if (sh_b > MAXV)      b_o = W'(MAXV);
    else if (sh_b < MINV) b_o = W'(MINV);
    else                  b_o = W'(sh_b);
  end
endmodule

// File: rtl/qr_givens_engine.sv
module qr_givens_engine
  import qr_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 16,
  parameter int FRAC = 14,
  localparam int M = N + 1,
  localparam int CW = $clog2(M),
  localparam int RW = (N > 1) ? $clog2(N) : 1,
  localparam int NW = W + FRAC
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [M*W-1:0]      in_data_i,
  input  logic [CW-1:0]       rd_row_i,
  input  logic [CW-1:0]       rd_col_i,
  output logic signed [W-1:0] rd_data_o
);
  localparam logic [W-1:0] ONE    = W'(1) << FRAC;
  localparam logic [W-1:0] MAXPOS = {1'b0, {(W-1){1'b1}}};

  logic signed [W-1:0] tri_q [N][M];
  logic signed [W-1:0] vec_q [M];
  logic signed [W-1:0] in_vec [M];

  for (genvar g = 0; g < M; g++) begin : g_unpack
    assign in_vec[g] = in_data_i[g*W +: W];
  end

  qr_state_e           state_q;
  logic [RW-1:0]       row_q;
  logic [CW-1:0]       col_q;
  logic signed [W-1:0] c_q, s_q, d_q;

  // boundary unit operands
  logic signed [W-1:0]   diag_r, diag_x;
  logic signed [2*W-1:0] pr, px;
  logic [2*W-1:0]        rad;
  logic [W-1:0]          x_abs, root, root_sat, q_clamp;
  logic                  sq_done, dv_done, dv_start;
  logic [NW-1:0]         dv_num, quo;
  logic [W-1:0]          dv_den;
  logic signed [W-1:0]   rot_a, rot_b;
  logic                  last_col, last_row;

  assign diag_r = tri_q[row_q][row_q];
  assign diag_x = vec_q[row_q];
  assign pr     = diag_r * diag_r;
  assign px     = diag_x * diag_x;
  assign rad    = $unsigned(pr) + $unsigned(px);
  assign x_abs  = diag_x[W-1] ? W'(-diag_x) : W'(diag_x);

  qr_isqrt #(.W(W)) u_sqrt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (state_q == ST_PREP),
    .rad_i   (rad),
    .done_o  (sq_done),
    .root_o  (root)
  );

  assign root_sat = (root > MAXPOS) ? MAXPOS : root;

  assign dv_num   = (state_q == ST_SQRT) ? {diag_r, {FRAC{1'b0}}} : {x_abs, {FRAC{1'b0}}};
  assign dv_den   = (state_q == ST_SQRT) ? root_sat : d_q;
  assign dv_start = (state_q == ST_SQRT && sq_done && root_sat != '0) ||
                    (state_q == ST_DIVC && dv_done);

  qr_divider #(.NW(NW), .DW(W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (dv_start),
    .num_i   (dv_num),
    .den_i   (dv_den),
    .done_o  (dv_done),
    .quo_o   (quo)
  );

  assign q_clamp = (quo > NW'(ONE)) ? ONE : W'(quo);

  qr_rotate #(.W(W), .FRAC(FRAC)) u_rot (
    .c_i (c_q),
    .s_i (s_q),
    .a_i (tri_q[row_q][col_q]),
    .b_i (vec_q[col_q]),
    .a_o (rot_a),
    .b_o (rot_b)
  );

  assign last_col = (col_q == CW'(N));
  assign last_row = (row_q == RW'(N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      c_q     <= '0;
      s_q     <= '0;
      d_q     <= '0;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < M; j++) tri_q[i][j] <= '0;
      for (int j = 0; j < M; j++) vec_q[j] <= '0;
    end else if (clear_i) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < M; j++) tri_q[i][j] <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (in_valid_i) begin
          for (int j = 0; j < M; j++) vec_q[j] <= in_vec[j];
          row_q   <= '0;
          state_q <= ST_PREP;
        end
        ST_PREP: state_q <= ST_SQRT;
        ST_SQRT: if (sq_done) begin
          d_q   <= root_sat;
          col_q <= CW'(row_q) + CW'(1);
          if (root_sat == '0) begin
            // degenerate row: pass everything through
            c_q     <= ONE;
            s_q     <= '0;
            state_q <= ST_ROT;
          end else begin
            state_q <= ST_DIVC;
          end
        end
        ST_DIVC: if (dv_done) begin
          c_q     <= q_clamp;
          state_q <= ST_DIVS;
        end
        ST_DIVS: if (dv_done) begin
          s_q     <= diag_x[W-1] ? -$signed(q_clamp) : $signed(q_clamp);
          state_q <= ST_ROT;
        end
        ST_ROT: begin
          tri_q[row_q][col_q] <= rot_a;
          vec_q[col_q]        <= rot_b;
          col_q               <= col_q + CW'(1);
          if (last_col) begin
            tri_q[row_q][row_q] <= d_q;
            if (last_row) begin
              state_q <= ST_IDLE;
            end else begin
              row_q   <= row_q + RW'(1);
              state_q <= ST_PREP;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready_o = (state_q == ST_IDLE);

  always_comb begin
    rd_data_o = '0;
    if (rd_row_i < CW'(N) && rd_col_i < CW'(M))
      rd_data_o = tri_q[rd_row_i[RW-1:0]][rd_col_i];
  end
endmodule

// File: rtl/qr_checker.sv
module qr_checker #(
  parameter int N = 4,
  parameter int W = 16,
  localparam int M = N + 1,
  localparam int CW = $clog2(M)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                clear_i,
  input logic                in_valid_i,
  input logic                in_ready_o,
  input logic [CW-1:0]       rd_row_i,
  input logic [CW-1:0]       rd_col_i,
  input logic signed [W-1:0] rd_data_o
);
  assert_below_diag_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_col_i < rd_row_i) |-> (rd_data_o == '0));

  assert_diag_nonneg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_col_i == rd_row_i) |-> !rd_data_o[W-1]);

  assert_ready_drops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && !clear_i) |=> !in_ready_o);

  assert_clear_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> in_ready_o);

  assert_clear_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (rd_data_o == '0));

  assert_read_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_col_i >= CW'(M) || rd_row_i >= CW'(N)) |-> (rd_data_o == '0));
endmodule

bind qr_givens_engine qr_checker #(.N(N), .W(W)) u_qr_checker (.*);

// File: tb/tb_qr_givens_engine.sv
module tb_qr_givens_engine;
  localparam int N = 4;
  localparam int W = 16;
  localparam int M = N + 1;
  localparam int CW = $clog2(M);
  localparam real TOL = 0.02;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic vin = 1'b0;
  logic [M*W-1:0] din = '0;
  logic [CW-1:0] rr = '0, rc = '0;
  logic rdy;
  logic signed [W-1:0] rd;

  always #10 clk = ~clk;

  qr_givens_engine #(.N(N), .W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .in_valid_i(vin),
    .in_ready_o(rdy), .in_data_i(din), .rd_row_i(rr), .rd_col_i(rc),
    .rd_data_o(rd)
  );

  int total = 0, bad = 0;
  real ref_m [N][M];
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(bit ok, string req, string what, real act, real exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%f expected=%f", req, what, act, exp);
    end
  endtask

  function automatic real q2r(logic signed [W-1:0] v);
    return $itor(v) / 16384.0;
  endfunction

  function automatic real fabs(real v);
    return (v < 0.0) ? -v : v;
  endfunction

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[29:16]) - 8192;
  endfunction

  function automatic logic [M*W-1:0] pack(int e0, int e1, int e2, int e3, int e4);
    return {W'(e4), W'(e3), W'(e2), W'(e1), W'(e0)};
  endfunction

  task automatic rd_at(int i, int j, output logic signed [W-1:0] v);
    rr = CW'(i);
    rc = CW'(j);
    #1;
    v = rd;
  endtask

  task automatic ref_clear();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < M; j++) ref_m[i][j] = 0.0;
  endtask

  // real-valued reference update (R2, R3, R4, R5)
  task automatic ref_update(logic [M*W-1:0] d);
    real v [M];
    real r, x, dd, c, s, a;
    for (int k = 0; k < M; k++) v[k] = q2r(d[k*W +: W]);
    for (int i = 0; i < N; i++) begin
      r = ref_m[i][i];
      x = v[i];
      dd = $sqrt(r * r + x * x);
      if (dd == 0.0) begin c = 1.0; s = 0.0; end
      else begin c = r / dd; s = x / dd; end
      ref_m[i][i] = dd;
      for (int j = i + 1; j < M; j++) begin
        a = ref_m[i][j];
        ref_m[i][j] = c * a + s * v[j];
        v[j] = c * v[j] - s * a;
      end
    end
  endtask

  task automatic send(logic [M*W-1:0] d);
    @(negedge clk);
    vin = 1'b1;
    din = d;
    @(negedge clk);
    vin = 1'b0;
    chk(rdy == 1'b0, "R6", "ready after accept", real'(rdy), 0.0);
    while (!rdy) @(negedge clk);
    ref_update(d);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    ref_clear();
  endtask

  task automatic compare_all(string tag);
    logic signed [W-1:0] v;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < M; j++) begin
        rd_at(i, j, v);
        if (j < i)
          chk(v == '0, "R1", {tag, " below diagonal"}, q2r(v), 0.0);
        else if (j == i)
          chk(!v[W-1] && fabs(q2r(v) - ref_m[i][j]) <= TOL, "R2",
              {tag, " diagonal"}, q2r(v), ref_m[i][j]);
        else if (j == N)
          chk(fabs(q2r(v) - ref_m[i][j]) <= TOL, "R8", {tag, " u column"},
              q2r(v), ref_m[i][j]);
        else
          chk(fabs(q2r(v) - ref_m[i][j]) <= TOL, "R4", {tag, " off diagonal"},
              q2r(v), ref_m[i][j]);
      end
  endtask

  task automatic expect_zero(string req, string tag);
    logic signed [W-1:0] v;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < M; j++) begin
        rd_at(i, j, v);
        chk(v == '0, req, tag, q2r(v), 0.0);
      end
  endtask

  task automatic expect_code(int i, int j, int exp, string req, string tag);
    logic signed [W-1:0] v;
    rd_at(i, j, v);
    chk(v == W'(exp), req, tag, real'(v), real'(exp));
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired R6 actual=busy expected=idle");
    summary();
  end

  initial begin
    logic signed [W-1:0] v;
    logic [M*W-1:0] snap;
    ref_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(rdy == 1'b1, "R6", "ready after reset", real'(rdy), 1.0);
    expect_zero("R1", "reset contents");

    // R8: out of range addresses
    rd_at(0, 7, v);
    chk(v == '0, "R8", "column out of range", q2r(v), 0.0);
    rd_at(5, 0, v);
    chk(v == '0, "R8", "row out of range", q2r(v), 0.0);

    // R3: first snapshot into empty triangle gives c=0, s=sign(x1), exact codes
    send(pack(8192, 4096, -4096, 2048, 6144));
    expect_code(0, 0, 8192, "R3", "diag from x1");
    expect_code(0, 1, 4096, "R3", "row0 col1");
    expect_code(0, 2, -4096, "R3", "row0 col2");
    expect_code(0, 4, 6144, "R3", "row0 u");
    expect_code(1, 1, 0, "R4", "row1 untouched");
    do_clear();
    send(pack(-8192, 4096, -4096, 2048, 6144));
    expect_code(0, 0, 8192, "R3", "diag nonneg for negative x1");
    expect_code(0, 1, -4096, "R3", "negative s row0 col1");
    expect_code(0, 4, -6144, "R3", "negative s row0 u");

    // R5: degenerate rows pass through
    do_clear();
    send(pack(0, 0, 0, 0, 0));
    expect_zero("R5", "zero snapshot on empty triangle");
    send(pack(0, 4096, -2048, 8192, 12288));
    expect_code(0, 0, 0, "R5", "row0 diag stays zero");
    expect_code(0, 2, 0, "R5", "row0 col2 stays zero");
    expect_code(0, 4, 0, "R5", "row0 u stays zero");
    expect_code(1, 1, 4096, "R5", "row1 takes passed x2");
    expect_code(1, 2, -2048, "R5", "row1 col2");
    expect_code(1, 3, 8192, "R5", "row1 col3");
    expect_code(1, 4, 12288, "R5", "row1 u");
    expect_code(2, 2, 0, "R5", "row2 empty");

    // R2, R4, R8: sweep of problems with growing snapshot counts
    for (int p = 0; p < 5; p++) begin
      do_clear();
      for (int k = 0; k < 6 + p; k++) begin
        snap = pack(rnd(), rnd(), rnd(), rnd(), rnd());
        send(snap);
      end
      compare_all($sformatf("problem %0d", p));
    end

    // R7: clear after a problem
    do_clear();
    chk(rdy == 1'b1, "R7", "ready after clear", real'(rdy), 1.0);
    expect_zero("R7", "contents after clear");

    // R7: clear in the middle of an update
    send(pack(rnd(), rnd(), rnd(), rnd(), rnd()));
    @(negedge clk);
    vin = 1'b1;
    din = pack(rnd(), rnd(), rnd(), rnd(), rnd());
    @(negedge clk);
    vin = 1'b0;
    repeat (40) @(negedge clk);
    chk(rdy == 1'b0, "R6", "busy mid update", real'(rdy), 0.0);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    ref_clear();
    chk(rdy == 1'b1, "R7", "ready after mid-update clear", real'(rdy), 1.0);
    expect_zero("R7", "contents after mid-update clear");

    // R1, R2: a fresh problem after the abort still tracks the reference
    for (int k = 0; k < 7; k++) send(pack(rnd(), rnd(), rnd(), rnd(), rnd()));
    compare_all("after abort");

    summary();
  end
endmodule